// File: doc/BRIEF.md
# Scrambled Grayscale PWM Generator

This block turns sixteen per-channel grayscale words into sixteen channel-enable signals for an LED sink array. A free-running period counter advances on a grayscale tick (a one-cycle enable on the system clock that stands in for the grayscale clock). Each channel compares its word against that counter, so a channel with value `g` is lit for `g` ticks out of every period. The period is 4096 ticks in short (12-bit) depth and 65536 ticks in wide (16-bit) depth.

Instead of one contiguous on-pulse, a segment mode cuts the period into 64, 16 or 4 equal segments. The high part of the word sets a run length inside every segment, and the low part adds one extra tick to the first few segments. The light is therefore spread as many short bursts, which reduces visible flicker at low refresh rates. A fourth mode gives a single linear pulse.

New words arrive on a wide input bus and are taken by a global-latch pulse. In immediate mode they reach the comparators at once. In deferred mode they wait in a holding buffer until the current period ends. The outputs are split into four groups by channel index modulo four, and each group is delayed by a further parameterised number of system-clock cycles to spread inrush current. A one-cycle end-of-period flag marks each counter wrap.

Top module: `gs_pwm_engine`

## Requirements
- R1: While `rstN` is low and after its release, before any latch, every `chanOn` bit and `cycleEnd` are 0.
- R2: With `gsTick` high every cycle, a channel with effective value g is on for exactly g cycles in any window of one full period, in every mode and depth. A word whose effective value is 0 never turns its channel on.
- R3: With `depth16`=0, the period is 4096 ticks and the effective value is word bits [15:4]. Bits [3:0] have no effect.
- R4: With `depth16`=1, the period is 65536 ticks and the effective value is the whole 16-bit word. Channel i takes `gsData[16i+15:16i]`.
- R5: `cntMode` 00, 01, 10 and 11 split the period into S = 64, 16, 4 and 1 segments of P = period/S ticks. At position t of segment k, a channel is on when t < g/S, or when t = g/S and k < g mod S. For 1 ≤ g/S < P-1 the channel therefore shows exactly S separate pulses per period.
- R6: With `manualSync`=1, a `gLatch` pulse loads the bus into the comparators at once. Group-0 outputs reflect the new words two cycles after the latch cycle.
- R7: With `manualSync`=0, latched words are held back. Outputs keep the old words up to and including the cycle in which `cycleEnd` is high, and the new words apply from the next period.
- R8: Channel i lags the group-0 channels by (i mod 4) × `STAGGER_CYC` system-clock cycles, both at turn-on and at turn-off.
- R9: `cycleEnd` is a one-cycle pulse in the cycle after the counter wraps. Consecutive pulses are one period of ticks apart.
- R10: While `gsTick` is low the counter holds, `cycleEnd` stays low, and the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gsTick | input | 1 | Grayscale tick; the period counter advances on cycles where it is high |
| depth16 | input | 1 | 1 = 16-bit depth, 0 = 12-bit depth |
| cntMode | input | 2 | Segment mode: 00=64, 01=16, 10=4, 11=1 segment |
| manualSync | input | 1 | 1 = apply latched words at once, 0 = defer to period end |
| gLatch | input | 1 | Global-latch pulse that takes `gsData` |
| gsData | input | NUM_CH*GS_W | Grayscale words, channel i at bits [16i+15:16i] |
| chanOn | output | NUM_CH | Per-channel enable after the group stagger |
| cycleEnd | output | 1 | End-of-period pulse |

## Verification
The bench builds the engine with 16 channels of 16-bit words and overrides the stagger to 3 cycles per group. This makes the group offsets of 0, 3, 6 and 9 cycles directly distinct from the two-cycle latch latency. With one tick per cycle, a full 12-bit period fits in about 4100 cycles, so all four segment modes, both sync modes, tick gating and the period spacing are measured over whole periods. A single 65536-cycle window covers the wide depth.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;

  typedef enum logic [1:0] {
    SEG_64 = 2'b00,
    SEG_16 = 2'b01,
    SEG_4  = 2'b10,
    SEG_1  = 2'b11
  } segMode_t;

  typedef struct packed {
    logic loadActive;
    logic loadPending;
    logic applyPending;
  } pwmStrobe_t;

endpackage

// File: rtl/gs_pwm_ctrl.sv
module gs_pwm_ctrl
  import gs_pwm_pkg::*;
#(
  parameter int GS_W       = 16,
  parameter int SHORT_DROP = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            gsTick,
  input  logic            depth16,
  input  logic            manualSync,
  input  logic            gLatch,
  output logic [GS_W-1:0] cnt,
  output pwmStrobe_t      strobe,
  output logic            cycleEnd
);

  localparam int SHORT_W = GS_W - SHORT_DROP;
  localparam logic [GS_W-1:0] FULL_TOP  = '1;
  localparam logic [GS_W-1:0] SHORT_TOP = {{SHORT_DROP{1'b0}}, {SHORT_W{1'b1}}};

  logic [GS_W-1:0] topVal;
  logic            wrap;
  logic            pendValid;

  assign topVal = depth16 ? FULL_TOP : SHORT_TOP;
  assign wrap   = gsTick && (cnt >= topVal);

  always_comb begin
    strobe.loadActive   = gLatch && manualSync;
    strobe.loadPending  = gLatch && !manualSync;
    strobe.applyPending = wrap && pendValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      pendValid <= 1'b0;
      cycleEnd  <= 1'b0;
    end else begin
      cycleEnd <= wrap;
      if (gsTick) begin
        cnt <= wrap ? '0 : cnt + 1'b1;
      end
      if (strobe.loadPending) begin
        pendValid <= 1'b1;
      end else if (strobe.applyPending) begin
        pendValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/gs_pwm_datapath.sv
module gs_pwm_datapath
  import gs_pwm_pkg::*;
#(
  parameter int NUM_CH       = 16,
  parameter int GS_W         = 16,
  parameter int SHORT_DROP   = 4,
  parameter int SEG_MAX_BITS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pwmStrobe_t             strobe,
  input  logic [GS_W-1:0]        cnt,
  input  logic                   depth16,
  input  logic [1:0]             cntMode,
  input  logic [NUM_CH*GS_W-1:0] gsData,
  output logic [NUM_CH-1:0]      rawOn
);

  localparam int SEG_STEP = SEG_MAX_BITS / 3;
  localparam int SHORT_W  = GS_W - SHORT_DROP;

  logic [NUM_CH*GS_W-1:0] activeWords;
  logic [NUM_CH*GS_W-1:0] pendWords;
  logic [NUM_CH-1:0]      onNext;

  function automatic logic segCompare(input logic [GS_W-1:0] word,
                                      input logic [GS_W-1:0] cntV,
                                      input logic            wide,
                                      input logic [1:0]      mode);
    logic [GS_W:0] one, g, c, q, r, t, k, segMask, posMask, depthMask;
    int dBits, sBits, posBits;
    one       = {{GS_W{1'b0}}, 1'b1};
    dBits     = wide ? GS_W : SHORT_W;
    sBits     = SEG_MAX_BITS - SEG_STEP * int'(mode);
    posBits   = dBits - sBits;
    depthMask = (one << dBits) - one;
    segMask   = (one << sBits) - one;
    posMask   = (one << posBits) - one;
    g = wide ? {1'b0, word}
             : {1'b0, {SHORT_DROP{1'b0}}, word[GS_W-1:SHORT_DROP]};
    c = {1'b0, cntV} & depthMask;
    q = g >> sBits;
    r = g & segMask;
    t = c & posMask;
    k = c >> posBits;
    return (t < q) || ((t == q) && (k < r));
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeWords <= '0;
      pendWords   <= '0;
    end else begin
      if (strobe.loadPending) begin
        pendWords <= gsData;
      end
      if (strobe.loadActive) begin
        activeWords <= gsData;
      end else if (strobe.applyPending) begin
        activeWords <= pendWords;
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    assign onNext[ch] = segCompare(activeWords[ch*GS_W +: GS_W], cnt, depth16, cntMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawOn <= '0;
    end else begin
      rawOn <= onNext;
    end
  end

endmodule

// File: rtl/gs_pwm_stagger.sv
module gs_pwm_stagger #(
  parameter int NUM_CH      = 16,
  parameter int NUM_GROUPS  = 4,
  parameter int STAGGER_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] rawOn,
  output logic [NUM_CH-1:0] chanOn
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int DLY = (ch % NUM_GROUPS) * STAGGER_CYC;
    if (DLY == 0) begin : g_direct
      assign chanOn[ch] = rawOn[ch];
    end else begin : g_delay
      logic [DLY-1:0] pipe;
      logic [DLY:0]   shifted;
      assign shifted = {pipe, rawOn[ch]};
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pipe <= '0;
        end else begin
          pipe <= shifted[DLY-1:0];
        end
      end
      assign chanOn[ch] = pipe[DLY-1];
    end
  end

endmodule

// File: rtl/gs_pwm_engine.sv
module gs_pwm_engine
  import gs_pwm_pkg::*;
#(
  parameter int NUM_CH       = 16,
  parameter int GS_W         = 16,
  parameter int SHORT_DROP   = 4,
  parameter int SEG_MAX_BITS = 6,
  parameter int NUM_GROUPS   = 4,
  parameter int STAGGER_CYC  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   gsTick,
  input  logic                   depth16,
  input  logic [1:0]             cntMode,
  input  logic                   manualSync,
  input  logic                   gLatch,
  input  logic [NUM_CH*GS_W-1:0] gsData,
  output logic [NUM_CH-1:0]      chanOn,
  output logic                   cycleEnd
);

  logic [GS_W-1:0]   cnt;
  pwmStrobe_t        strobe;
  logic [NUM_CH-1:0] rawOn;

  gs_pwm_ctrl #(.GS_W(GS_W), .SHORT_DROP(SHORT_DROP)) ctrl_i (
    .clk(clk), .rstN(rstN), .gsTick(gsTick), .depth16(depth16),
    .manualSync(manualSync), .gLatch(gLatch), .cnt(cnt),
    .strobe(strobe), .cycleEnd(cycleEnd)
  );

  gs_pwm_datapath #(.NUM_CH(NUM_CH), .GS_W(GS_W), .SHORT_DROP(SHORT_DROP),
                    .SEG_MAX_BITS(SEG_MAX_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cnt(cnt), .depth16(depth16),
    .cntMode(cntMode), .gsData(gsData), .rawOn(rawOn)
  );

  gs_pwm_stagger #(.NUM_CH(NUM_CH), .NUM_GROUPS(NUM_GROUPS),
                   .STAGGER_CYC(STAGGER_CYC)) stg_i (
    .clk(clk), .rstN(rstN), .rawOn(rawOn), .chanOn(chanOn)
  );

endmodule

// File: rtl/gs_pwm_engine_chk.sv
module gs_pwm_engine_chk #(
  parameter int GS_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            gsTick,
  input logic            gLatch,
  input logic            manualSync,
  input logic            depth16,
  input logic [1:0]      cntMode,
  input logic [GS_W-1:0] gsData0,
  input logic            chanOn0,
  input logic            cycleEnd
);

  // R9
  cycle_end_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleEnd |=> !cycleEnd);

  // R10
  idle_no_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gsTick |=> !cycleEnd);

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!gsTick && !gLatch) && $stable({depth16, cntMode})) |=> $stable(chanOn0));

  // R2
  zero_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gLatch && manualSync && (gsData0 == '0)) |=> ##1 !chanOn0);

endmodule

bind gs_pwm_engine gs_pwm_engine_chk #(.GS_W(GS_W)) chk_i (
  .clk(clk), .rstN(rstN), .gsTick(gsTick), .gLatch(gLatch),
  .manualSync(manualSync), .depth16(depth16), .cntMode(cntMode),
  .gsData0(gsData[GS_W-1:0]), .chanOn0(chanOn[0]), .cycleEnd(cycleEnd)
);

// File: tb/gs_pwm_engine_tb.sv
module gs_pwm_engine_tb_top;
  localparam int NUM_CH = 16;
  localparam int GS_W   = 16;
  localparam int STG    = 3;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   gsTick = 1'b0;
  logic                   depth16 = 1'b0;
  logic [1:0]             cntMode = 2'b00;
  logic                   manualSync = 1'b1;
  logic                   gLatch = 1'b0;
  logic [NUM_CH*GS_W-1:0] gsData = '0;
  logic [NUM_CH-1:0]      chanOn;
  logic                   cycleEnd;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int onCnt [NUM_CH];
  int riseCnt [NUM_CH];
  logic [15:0] words [NUM_CH];

  always #2 clk = ~clk;

  gs_pwm_engine #(.NUM_CH(NUM_CH), .GS_W(GS_W), .STAGGER_CYC(STG)) dut_i (
    .clk(clk), .rstN(rstN), .gsTick(gsTick), .depth16(depth16), .cntMode(cntMode),
    .manualSync(manualSync), .gLatch(gLatch), .gsData(gsData),
    .chanOn(chanOn), .cycleEnd(cycleEnd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fillAll(input logic [15:0] w);
    for (int i = 0; i < NUM_CH; i++) words[i] = w;
  endtask

  task automatic latchWords();
    @(negedge clk);
    for (int i = 0; i < NUM_CH; i++) gsData[i*GS_W +: GS_W] = words[i];
    gLatch = 1'b1;
    @(negedge clk);
    gLatch = 1'b0;
  endtask

  task automatic measure(input int n);
    logic [NUM_CH-1:0] prev;
    @(negedge clk);
    prev = chanOn;
    for (int i = 0; i < NUM_CH; i++) begin onCnt[i] = 0; riseCnt[i] = 0; end
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < NUM_CH; i++) begin
        if (chanOn[i]) onCnt[i]++;
        if (chanOn[i] && !prev[i]) riseCnt[i]++;
      end
      prev = chanOn;
    end
  endtask

  task automatic waitCycleEnd();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cycleEnd && n < 70000);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(chanOn == '0, "R1", "chanOn in reset", int'(chanOn), 0);
    check(cycleEnd == 1'b0, "R1", "cycleEnd in reset", int'(cycleEnd), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(chanOn == '0, "R1", "chanOn after release", int'(chanOn), 0);
  endtask

  task automatic testDuty12();
    int bad = 0;
    depth16 = 1'b0; cntMode = 2'b00; manualSync = 1'b1; gsTick = 1'b1;
    for (int i = 0; i < NUM_CH; i++) words[i] = 16'(i * 4369 + 1234);
    words[5] = 16'h0000; words[15] = 16'hFFFF;
    latchWords();
    repeat (20) @(negedge clk);
    measure(4096);
    for (int i = 0; i < NUM_CH; i++) begin
      if (onCnt[i] != int'(words[i] >> 4)) begin
        bad++;
        check(1'b0, "R3", $sformatf("12-bit duty ch%0d", i), onCnt[i], int'(words[i] >> 4));
      end
    end
    check(bad == 0, "R2", "12-bit duty all channels", bad, 0);
    check(onCnt[5] == 0, "R2", "zero word stays off", onCnt[5], 0);
    check(onCnt[15] == 4095, "R3", "max word ignores low nibble", onCnt[15], 4095);
  endtask

  task automatic testModes();
    int segs [4] = '{64, 16, 4, 1};
    fillAll(16'h0C8A);
    latchWords();
    for (int m = 0; m < 4; m++) begin
      cntMode = 2'(m);
      repeat (20) @(negedge clk);
      measure(4096);
      check(riseCnt[0] == segs[m], "R5", $sformatf("pulses mode %0d ch0", m), riseCnt[0], segs[m]);
      check(riseCnt[7] == segs[m], "R5", $sformatf("pulses mode %0d ch7", m), riseCnt[7], segs[m]);
      check(onCnt[3] == 200, "R2", $sformatf("duty mode %0d ch3", m), onCnt[3], 200);
    end
  endtask

  task automatic testDuty16();
    int bad = 0;
    depth16 = 1'b1; cntMode = 2'b00;
    for (int i = 0; i < NUM_CH; i++) words[i] = 16'(i * 4369 + 1234);
    words[5] = 16'h0000; words[15] = 16'hFFFF;
    latchWords();
    repeat (20) @(negedge clk);
    measure(65536);
    for (int i = 0; i < NUM_CH; i++) begin
      if (onCnt[i] != int'(words[i])) begin
        bad++;
        check(1'b0, "R4", $sformatf("16-bit duty ch%0d", i), onCnt[i], int'(words[i]));
      end
    end
    check(bad == 0, "R4", "16-bit duty all channels", bad, 0);
    check(onCnt[15] == 65535, "R4", "16-bit max word", onCnt[15], 65535);
    depth16 = 1'b0;
  endtask

  task automatic testAutoSync();
    int early = 0;
    int n = 0;
    cntMode = 2'b11; manualSync = 1'b1;
    fillAll(16'h0000);
    latchWords();
    repeat (20) @(negedge clk);
    manualSync = 1'b0;
    waitCycleEnd();
    repeat (1000) @(negedge clk);
    fillAll(16'hFFF0);
    latchWords();
    do begin
      for (int i = 0; i < NUM_CH; i++) if (chanOn[i]) early++;
      if (!cycleEnd) @(negedge clk);
      n++;
    end while (!cycleEnd && n < 5000);
    for (int i = 0; i < NUM_CH; i++) if (chanOn[i]) early++;
    check(early == 0, "R7", "deferred words held until period end", early, 0);
    check(n > 2000, "R7", "period end not premature", n, 3095);
    repeat (20) @(negedge clk);
    measure(4096);
    check(onCnt[0] == 4095, "R7", "deferred words applied next period", onCnt[0], 4095);
    manualSync = 1'b1;
  endtask

  task automatic testManualSync();
    int hi = 0;
    fillAll(16'h0000);
    latchWords();
    repeat (20) @(negedge clk);
    waitCycleEnd();
    fillAll(16'hFFF0);
    latchWords();
    check(chanOn[0] == 1'b0, "R6", "one cycle after latch still old", int'(chanOn[0]), 0);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      if (chanOn[0]) hi++;
    end
    check(hi == 8, "R6", "group0 on from second cycle", hi, 8);
  endtask

  task automatic testStagger();
    int first [NUM_CH];
    fillAll(16'h0000);
    latchWords();
    repeat (20) @(negedge clk);
    waitCycleEnd();
    fillAll(16'hFFF0);
    for (int i = 0; i < NUM_CH; i++) first[i] = -1;
    latchWords();
    for (int s = 1; s <= 40; s++) begin
      if (s > 1) @(negedge clk);
      for (int i = 0; i < NUM_CH; i++) if (chanOn[i] && first[i] < 0) first[i] = s;
    end
    check(first[0] == 2, "R8", "group0 first on", first[0], 2);
    for (int i = 1; i < NUM_CH; i++)
      check(first[i] - first[0] == (i % 4) * STG, "R8", $sformatf("stagger ch%0d", i),
            first[i] - first[0], (i % 4) * STG);
  endtask

  task automatic testPeriod();
    int n = 0;
    int diffs = 0;
    int ends = 0;
    logic [NUM_CH-1:0] snap;
    waitCycleEnd();
    do begin @(negedge clk); n++; end while (!cycleEnd && n < 20000);
    check(n == 4096, "R9", "cycleEnd spacing full rate", n, 4096);
    waitCycleEnd();
    n = 0;
    do begin @(negedge clk); gsTick = ~gsTick; n++; end while (!cycleEnd && n < 20000);
    do begin @(negedge clk); gsTick = ~gsTick; n = (n == 0) ? 0 : n; end while (cycleEnd);
    n = 1;
    do begin @(negedge clk); gsTick = ~gsTick; n++; end while (!cycleEnd && n < 20000);
    check(n == 8192, "R9", "cycleEnd spacing half rate", n, 8192);
    fillAll(16'h0C8A);
    cntMode = 2'b00;
    @(negedge clk); gsTick = 1'b1;
    latchWords();
    repeat (100) @(negedge clk);
    gsTick = 1'b0;
    repeat (20) @(negedge clk);
    snap = chanOn;
    repeat (5000) begin
      @(negedge clk);
      if (chanOn != snap) diffs++;
      if (cycleEnd) ends++;
    end
    check(diffs == 0, "R10", "outputs hold with tick low", diffs, 0);
    check(ends == 0, "R10", "no cycleEnd with tick low", ends, 0);
    gsTick = 1'b1;
  endtask

  initial begin
    testReset();
    testDuty12();
    testModes();
    testDuty16();
    testAutoSync();
    testManualSync();
    testStagger();
    testPeriod();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule